// File: doc/BRIEF.md
# Boot-Sector Flash Command Controller

This block models the command interface of a byte-wide flash memory with a boot-sector layout. The host drives a bus with chip enable, write enable and output enable, all active low. The block samples them on the rising clock edge. A write strobe is one cycle with chip enable and write enable low. A read strobe is one cycle with chip enable and output enable low and write enable high. Write strobes are decoded as unlock/command sequences. Program and erase operations run internally on a byte array and are timed in clock cycles. Each read strobe returns either array data or a status byte, and the result is registered on `dout`.

The array is split into seven sectors over 32 equal address units. The parameter `TOP_BOOT` puts the small sectors at the top of the address space; otherwise they sit at the bottom. `UNIT_AW` sets the unit size, and `UNIT_AW=12` gives the full 128K x 8 array. A per-sector lock input guards sectors against program and erase. Erase can be suspended, so that other sectors can be read and programmed, and then resumed. An unlock-bypass mode shortens repeated programming. An identification mode returns a manufacturer code, a device code and the lock state of a sector.

Top module: `bootflash_ctrl`

## Requirements
- R1: While `rst_n` is low, `dout` is 00h. After reset, reads return array bytes.
- R2: Sector map, counted in 32 units from the low address end. Bottom boot uses sectors of 2,1,1,4,8,8,8 units. Top boot uses 8,8,8,4,1,1,2 units. A sector erase changes only the bytes of its own sector.
- R3: The sequence AAh@555h, 55h@2AAh, 90h@555h enters identification mode. In this mode a read with address bits [1:0]=0 gives `MFR_CODE`. With bits [1:0]=1 it gives EDh (top boot) or 6Dh (bottom boot). With bits [1:0]=2 it gives 01h if the addressed sector is locked and 00h if not. Writing F0h returns to array reads.
- R4: A program uses AAh@555h, 55h@2AAh, A0h@555h, then the data at the target address. The result is the old byte ANDed with the data, written after `PGM_CYC` cycles. While busy, status bit 7 reads as the complement of data bit 7.
- R5: Status bit 6 inverts on each successive status read while a program or erase is busy, and also during erase suspend.
- R6: During an erase, status bit 2 inverts on successive reads of an address in a selected sector and holds its value on reads of other sectors. Status bit 7 is 0 during an erase.
- R7: Erase uses AAh, 55h, 80h, AAh, 55h, then 10h@555h for the whole chip or 30h at a sector address. Further 30h writes within `WIN_CYC` cycles of the last one add sectors. The erase writes 00h and then FFh over every selected byte.
- R8: A byte in a sector whose `lock_sec` bit is set is never changed by program or erase.
- R9: B0h written during an erase suspends it. Reads of unselected sectors then return array data. Reads of selected sectors return status with bit 7 set and bits 6 and 2 toggling. A write of 30h resumes the erase and it completes.
- R10: While suspended, a program to an unselected sector completes and the block goes back to suspend. A program to a selected sector is ignored.
- R11: AAh, 55h, 20h enters bypass mode. In bypass, A0h followed by address/data programs a byte. 90h followed by 00h leaves bypass, after which A0h/data alone programs nothing.
- R12: A low `rst_n` aborts an ongoing program without writing the byte and returns the block to array reads.
- R13: A write that breaks an unlock sequence returns the decoder to read mode, and the data cycles that follow program nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | UNIT_AW+5 | Byte address |
| din | input | 8 | Write data / command byte |
| lock_sec | input | 7 | Per-sector lock, bit n guards sector n (numbered from low addresses) |
| dout | output | 8 | Registered read data or status |

## Verification
Most faults in this block show up as a wrong byte, or a byte that never changes, on the read that follows the operation. A decoder stuck in the wrong command state shows on the next read, because it returns identification or status data where array data was expected. A wrong sector boundary or lock check is only visible after the erase walk has finished, about two array depths later. A toggle flop that fails to invert shows up on the second of two back-to-back status reads.

// File: rtl/bootflash_ctrl.sv
module bootflash_ctrl #(
  parameter bit         TOP_BOOT = 1'b0,
  parameter int         UNIT_AW  = 4,
  parameter int         PGM_CYC  = 8,
  parameter int         WIN_CYC  = 16,
  parameter logic [7:0] MFR_CODE = 8'hC5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic [UNIT_AW+4:0] addr,
  input  logic [7:0]         din,
  input  logic [6:0]         lock_sec,
  output logic [7:0]         dout
);
  localparam int AW    = UNIT_AW + 5;
  localparam int DEPTH = 1 << AW;
  localparam int NSEC  = 7;
  localparam int CMDW  = (AW < 11) ? AW : 11;
  localparam int CW    = 16;
  localparam logic [7:0]  DEV_CODE = TOP_BOOT ? 8'hED : 8'h6D;
  localparam logic [10:0] KEY1 = 11'h555;
  localparam logic [10:0] KEY2 = 11'h2AA;

  typedef enum logic [3:0] {C_RD, C_U1, C_U2, C_PGM, C_E1, C_E2, C_E3,
                            C_AUTO, C_BYP, C_BPGM, C_BRST} cmd_t;
  typedef enum logic [2:0] {O_IDLE, O_PGM, O_WIN, O_ERS, O_SUSP} op_t;

  function automatic logic [2:0] sec_of(input logic [AW-1:0] a);
    logic [4:0] u;
    u = a[AW-1 -: 5];
    if (TOP_BOOT) begin
      if (u < 5'd8)       return 3'd0;
      else if (u < 5'd16) return 3'd1;
      else if (u < 5'd24) return 3'd2;
      else if (u < 5'd28) return 3'd3;
      else if (u == 5'd28) return 3'd4;
      else if (u == 5'd29) return 3'd5;
      else                return 3'd6;
    end else begin
      if (u < 5'd2)       return 3'd0;
      else if (u == 5'd2) return 3'd1;
      else if (u == 5'd3) return 3'd2;
      else if (u < 5'd8)  return 3'd3;
      else if (u < 5'd16) return 3'd4;
      else if (u < 5'd24) return 3'd5;
      else                return 3'd6;
    end
  endfunction

  cmd_t            cmd, cmd_nx;
  op_t             op;
  logic [NSEC-1:0] sel;
  logic [AW-1:0]   pa, ptr;
  logic [7:0]      pd;
  logic [CW-1:0]   cnt;
  logic            ph, susp_pgm, t6, t2;
  logic [7:0]      mem [DEPTH];

  wire wr    = !ce_n && !we_n;
  wire rd    = !ce_n && !oe_n && we_n;
  wire [2:0] asec = sec_of(addr);
  wire is1   = addr[CMDW-1:0] == KEY1[CMDW-1:0];
  wire is2   = addr[CMDW-1:0] == KEY2[CMDW-1:0];
  wire susp  = op == O_SUSP;
  wire busy  = op == O_PGM || op == O_WIN || op == O_ERS;
  wire hit   = sel[asec];
  wire pgm_ok = !lock_sec[asec] && !(susp && hit);

  logic pgm_go, chip_go, sec_go, resume;
  always_comb begin
    cmd_nx = cmd; pgm_go = 1'b0; chip_go = 1'b0; sec_go = 1'b0; resume = 1'b0;
    if (wr && !busy) begin
      case (cmd)
        C_RD:   if (is1 && din == 8'hAA) cmd_nx = C_U1;
                else if (susp && din == 8'h30) resume = 1'b1;
        C_U1:   cmd_nx = (is2 && din == 8'h55) ? C_U2 : C_RD;
        C_U2: begin
          cmd_nx = C_RD;
          if (is1) begin
            if (din == 8'hA0)               cmd_nx = C_PGM;
            else if (din == 8'h80 && !susp) cmd_nx = C_E1;
            else if (din == 8'h90)          cmd_nx = C_AUTO;
            else if (din == 8'h20 && !susp) cmd_nx = C_BYP;
          end
        end
        C_PGM:  begin cmd_nx = C_RD; pgm_go = pgm_ok; end
        C_E1:   cmd_nx = (is1 && din == 8'hAA) ? C_E2 : C_RD;
        C_E2:   cmd_nx = (is2 && din == 8'h55) ? C_E3 : C_RD;
        C_E3: begin
          cmd_nx  = C_RD;
          chip_go = is1 && din == 8'h10;
          sec_go  = din == 8'h30;
        end
        C_AUTO: if (din == 8'hF0) cmd_nx = C_RD;
        C_BYP:  if (din == 8'hA0) cmd_nx = C_BPGM;
                else if (din == 8'h90) cmd_nx = C_BRST;
        C_BPGM: begin cmd_nx = C_BYP; pgm_go = pgm_ok; end
        C_BRST: cmd_nx = (din == 8'h00) ? C_RD : C_BYP;
        default: cmd_nx = C_RD;
      endcase
    end
  end

  wire st_pgm  = op == O_PGM;
  wire st_ers  = op == O_WIN || op == O_ERS;
  wire st_susp = susp && hit && cmd != C_AUTO;
  wire rd_stat = rd && (st_pgm || st_ers || st_susp);
  wire t2_en   = ((st_ers || st_susp) && hit) || (st_pgm && susp_pgm && hit);
  wire b7      = st_pgm ? ~pd[7] : st_susp;
  wire [7:0] stat = {b7, t6, 2'b00, op == O_ERS, t2, 2'b00};

  logic [7:0] id_byte;
  always_comb begin
    case (addr[1:0])
      2'd0:    id_byte = MFR_CODE;
      2'd1:    id_byte = DEV_CODE;
      2'd2:    id_byte = {7'd0, lock_sec[asec]};
      default: id_byte = 8'h00;
    endcase
  end

  wire [7:0] rdata = rd_stat ? stat : (cmd == C_AUTO) ? id_byte : mem[addr];

  wire pgm_last = st_pgm && cnt == CW'(PGM_CYC - 1);
  wire ers_stop = wr && din == 8'hB0;
  wire pgm_wr = pgm_last && !lock_sec[sec_of(pa)];
  wire ers_wr = op == O_ERS && !ers_stop && sel[sec_of(ptr)] && !lock_sec[sec_of(ptr)];
  wire [AW-1:0] mem_wa = pgm_wr ? pa : ptr;
  wire [7:0]    mem_wd = pgm_wr ? (mem[pa] & pd) : {8{ph}};

  always_ff @(posedge clk)
    if (pgm_wr || ers_wr) mem[mem_wa] <= mem_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= C_RD; op <= O_IDLE; sel <= '0; pa <= '0; pd <= '0; ptr <= '0;
      cnt <= '0; ph <= 1'b0; susp_pgm <= 1'b0; t6 <= 1'b0; t2 <= 1'b0; dout <= 8'h00;
    end else begin
      cmd <= cmd_nx;
      if (rd) dout <= rdata;
      if (rd_stat) t6 <= ~t6;
      if (rd && t2_en) t2 <= ~t2;
      case (op)
        O_IDLE, O_SUSP:
          if (pgm_go) begin
            op <= O_PGM; pa <= addr; pd <= din; cnt <= '0; susp_pgm <= susp;
          end else if (chip_go) begin
            op <= O_ERS; sel <= '1; ptr <= '0; ph <= 1'b0;
          end else if (sec_go) begin
            op <= O_WIN; sel <= NSEC'(1) << asec; cnt <= '0;
          end else if (resume) op <= O_ERS;
        O_PGM:
          if (pgm_last) op <= susp_pgm ? O_SUSP : O_IDLE;
          else cnt <= cnt + 1'b1;
        O_WIN:
          if (wr && din == 8'h30) begin sel[asec] <= 1'b1; cnt <= '0; end
          else if (cnt == CW'(WIN_CYC - 1)) begin op <= O_ERS; ptr <= '0; ph <= 1'b0; end
          else cnt <= cnt + 1'b1;
        O_ERS:
          if (ers_stop) op <= O_SUSP;
          else begin
            ptr <= ptr + 1'b1;
            if (ptr == AW'(DEPTH - 1)) begin
              if (ph) begin op <= O_IDLE; sel <= '0; end
              else ph <= 1'b1;
            end
          end
        default: op <= O_IDLE;
      endcase
    end
  end

  a_r4_pgm_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (op == O_PGM) |-> (cnt < CW'(PGM_CYC)));
  a_r5_tog_flips: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (t6 != $past(t6)));
  a_r7_idle_nosel: assert property (@(posedge clk) disable iff (!rst_n)
    (op == O_IDLE) |-> (sel == '0));
  a_r9_susp_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (op == O_SUSP) |-> (sel != '0));
  a_r10_susp_pgm_target: assert property (@(posedge clk) disable iff (!rst_n)
    (op == O_PGM && susp_pgm) |-> !sel[sec_of(pa)]);
  a_r12_reset_read_mode: assert property (@(posedge clk)
    $rose(rst_n) |-> (op == O_IDLE && cmd == C_RD));
endmodule

// File: tb/bootflash_ctrl_tb.sv
`timescale 1ns/1ps
module bootflash_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0] addr = '0;
  logic [7:0] din = '0;
  logic [6:0] lock_sec = '0;
  logic [7:0] dout;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bootflash_ctrl u_dut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .lock_sec(lock_sec), .dout(dout));

  // {address, program data, expected byte}
  localparam logic [24:0] VEC [6] = '{
    {9'd5,   8'hF0, 8'hF0}, {9'd5,   8'h3C, 8'h30}, {9'd33,  8'h00, 8'h00},
    {9'd70,  8'hA5, 8'hA5}, {9'd300, 8'h7E, 8'h7E}, {9'd511, 8'h81, 8'h81}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); d = dout; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic cmd3(input logic [7:0] c);
    wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55); wr(9'h155, c);
  endtask

  task automatic ers_setup();
    cmd3(8'h80); wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55);
  endtask

  task automatic prog(input logic [8:0] a, input logic [7:0] d);
    cmd3(8'hA0); wr(a, d); idle(12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] x, y;
    idle(3);
    chk("R1 dout in reset", dout, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R7 chip erase, R5 toggle during erase
    ers_setup(); wr(9'h155, 8'h10);
    rd(9'd0, x); rd(9'd0, y);
    chk("R5 bit6 toggles in erase", {7'd0, x[6] ^ y[6]}, 8'h01);
    chk("R6 bit7 low in erase", {7'd0, x[7]}, 8'h00);
    idle(1100);
    rd(9'd0, x);   chk("R7 chip erase low", x, 8'hFF);
    rd(9'd200, x); chk("R7 chip erase mid", x, 8'hFF);
    rd(9'd511, x); chk("R1 array read after reset", x, 8'hFF);

    // R4 program table
    for (int i = 0; i < 6; i++) begin
      cmd3(8'hA0); wr(VEC[i][24:16], VEC[i][15:8]);
      rd(VEC[i][24:16], x);
      chk("R4 busy bit7 complement", {7'd0, x[7]}, {7'd0, ~VEC[i][15]});
      idle(12);
      rd(VEC[i][24:16], x);
      chk("R4 programmed byte", x, VEC[i][7:0]);
    end

    // R13 broken unlock sequence
    wr(9'h155, 8'hAA); wr(9'h155, 8'h55); wr(9'h155, 8'hA0); wr(9'd200, 8'h00);
    rd(9'd200, x); chk("R13 broken sequence no status", x, 8'hFF);
    idle(12);
    rd(9'd200, x); chk("R13 broken sequence no program", x, 8'hFF);

    // R2 / R6 sector erase of sector 2 (addresses 48..63)
    prog(9'd47, 8'h00); prog(9'd48, 8'h00); prog(9'd63, 8'h00); prog(9'd64, 8'h00);
    ers_setup(); wr(9'd50, 8'h30);
    idle(20);
    rd(9'd48, x); rd(9'd48, y);
    chk("R6 bit2 toggles in selected sector", {7'd0, x[2] ^ y[2]}, 8'h01);
    rd(9'd47, x); rd(9'd47, y);
    chk("R6 bit2 steady outside selection", {7'd0, x[2] ^ y[2]}, 8'h00);
    idle(1100);
    rd(9'd47, x); chk("R2 below sector kept", x, 8'h00);
    rd(9'd48, x); chk("R2 sector start erased", x, 8'hFF);
    rd(9'd63, x); chk("R2 sector end erased", x, 8'hFF);
    rd(9'd64, x); chk("R2 above sector kept", x, 8'h00);

    // R7 multi-sector erase within window: sectors 0 and 3
    ers_setup(); wr(9'd0, 8'h30); wr(9'd70, 8'h30);
    idle(1100);
    rd(9'd5, x);  chk("R7 first queued sector", x, 8'hFF);
    rd(9'd70, x); chk("R7 second queued sector", x, 8'hFF);
    rd(9'd33, x); chk("R7 unqueued sector kept", x, 8'h00);

    // R11 unlock bypass
    cmd3(8'h20);
    wr(9'd0, 8'hA0); wr(9'd100, 8'hC3); idle(12);
    rd(9'd100, x); chk("R11 bypass program", x, 8'hC3);
    wr(9'd0, 8'h90); wr(9'd0, 8'h00);
    wr(9'd0, 8'hA0); wr(9'd101, 8'h00); idle(12);
    rd(9'd101, x); chk("R11 after bypass exit", x, 8'hFF);

    // R9 / R10 suspend and resume of sector 6 erase
    prog(9'd10, 8'h12);
    ers_setup(); wr(9'd400, 8'h30);
    idle(20);
    wr(9'd0, 8'hB0);
    rd(9'd10, x); chk("R9 read unselected in suspend", x, 8'h12);
    rd(9'd400, x); rd(9'd400, y);
    chk("R9 suspend bit7 set", {7'd0, x[7]}, 8'h01);
    chk("R9 suspend bit6 toggles", {7'd0, x[6] ^ y[6]}, 8'h01);
    chk("R9 suspend bit2 toggles", {7'd0, x[2] ^ y[2]}, 8'h01);
    prog(9'd40, 8'h5A);
    rd(9'd40, x); chk("R10 program in suspend", x, 8'h5A);
    prog(9'd400, 8'h00);
    rd(9'd400, x); chk("R10 still suspended", {7'd0, x[7]}, 8'h01);
    wr(9'd0, 8'h30);
    idle(1100);
    rd(9'd400, x); chk("R9 resumed erase done", x, 8'hFF);
    rd(9'd511, x); chk("R9 resumed erase sector end", x, 8'hFF);
    rd(9'd40, x);  chk("R10 suspended program kept", x, 8'h5A);

    // R8 lock, R3 identification
    prog(9'd0, 8'h11);
    lock_sec = 7'b0100000;
    prog(9'd300, 8'h00);
    rd(9'd300, x); chk("R8 locked program ignored", x, 8'h7E);
    cmd3(8'h90);
    rd(9'h000, x); chk("R3 manufacturer code", x, 8'hC5);
    rd(9'h001, x); chk("R3 device code bottom boot", x, 8'h6D);
    rd(9'h102, x); chk("R3 locked sector flag", x, 8'h01);
    rd(9'h002, x); chk("R3 unlocked sector flag", x, 8'h00);
    wr(9'd0, 8'hF0);
    rd(9'd0, x); chk("R3 exit to array", x, 8'h11);
    ers_setup(); wr(9'h155, 8'h10);
    idle(1100);
    rd(9'd300, x); chk("R8 locked erase ignored", x, 8'h7E);
    rd(9'd0, x);   chk("R8 unlocked sector erased", x, 8'hFF);
    lock_sec = 7'b0;

    // R12 hardware reset aborts program
    cmd3(8'hA0); wr(9'd200, 8'h00);
    idle(3);
    rst_n = 1'b0; idle(2); rst_n = 1'b1;
    rd(9'd200, x); chk("R12 read mode after reset", x, 8'hFF);
    idle(12);
    rd(9'd200, x); chk("R12 aborted byte unchanged", x, 8'hFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule